// File: doc/BRIEF.md
# Synchronous I2S Bit-Clock and Word-Select Generator with Reclocking

This block derives the serial audio bit clock and word select from one master clock running at 256 times the sample rate. A free-running binary counter advances once per master-clock cycle. One of its bits gives the bit clock at a quarter of the master rate, and its top bit gives word select, so one frame holds 64 bit-clock periods. Every output leaves a flip-flop clocked by the same master-clock edge, so no divided output ripples behind another.

The block can also act as a slave. In that mode the incoming bit clock and word select pass through a two-stage master-clock register and then replace the generated pair. The serial data line is always retimed through the same two stages, whichever mode is chosen. After retiming, the bit clock can be held back by zero to three master cycles, so that it lines up again with data that slow downstream logic has delayed. The delay setting is only taken up on a word-select transition, so the bit-clock phase never jumps in the middle of a frame.

Top module: `i2s_sync_reclock`

## Requirements
- R1: While `rst_n` is low, `bclk_out`, `ws_out` and `sd_out` are all 0, whatever the other inputs do.
- R2: In master mode (`master_mode`=1), counting master-clock rising edges e from the first edge after `rst_n` goes high (e=1), `bclk_out` after edge e equals bit 1 of ((e-4-d) mod 256), or 0 while e-4-d < 0, where d is the active delay. This gives a bit-clock period of 4 master cycles at 50% duty.
- R3: In master mode, `ws_out` after edge e equals bit 7 of ((e-4) mod 256), or 0 while e < 4. The frame is 256 master cycles long and starts with 128 cycles low (left channel).
- R4: In master mode with d=0, `ws_out` changes only on an edge where `bclk_out` falls.
- R5: `sd_out` after edge e equals the value of `sd_in` captured at edge e-2, in both modes (0 while that edge is earlier than edge 3).
- R6: In slave mode (`master_mode`=0), `ws_out` after edge e equals `s_ws` captured at edge e-2, and `bclk_out` equals `s_bclk` captured at edge e-2-d (0 while that edge is earlier than edge 3).
- R7: The active delay d takes the value of `dly_sel` (0 to 3). It moves only `bclk_out`, by d master cycles, and leaves `ws_out` and `sd_out` unchanged.
- R8: `dly_sel` is taken up only on a transition of the selected word select, and the new delay applies from the edge after `ws_out` changes. A change of `dly_sel` within a frame has no effect on `bclk_out` until then. After reset, d is 0.
- R9: Driving `rst_n` low clears all three outputs at once, without waiting for a master-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released through a two-flop synchronizer |
| master_mode | input | 1 | 1 = generate bit clock and word select, 0 = retime the incoming pair |
| dly_sel | input | 2 | Requested bit-clock delay in master cycles (0 to 3) |
| s_bclk | input | 1 | Incoming bit clock, used in slave mode |
| s_ws | input | 1 | Incoming word select, used in slave mode |
| sd_in | input | 1 | Incoming serial data |
| bclk_out | output | 1 | Retimed bit clock |
| ws_out | output | 1 | Retimed word select |
| sd_out | output | 1 | Retimed serial data |

## Verification
The bench builds the block with its default parameters: an 8-bit frame counter, the bit clock taken from counter bit 1, two retiming stages and a longest delay of three cycles. With these values the bench can cover a complete 256-cycle frame, both word-select polarities and every one of the four delay taps in both modes, each within a few hundred cycles. The same settings leave room for a directed test of a delay change made within a frame, and for an asynchronous reset applied between clock edges.

// File: rtl/i2s_rc_pkg.sv
package i2s_rc_pkg;

  // One retimed serial-audio lane: clock, frame strobe, data.
  typedef struct packed {
    logic bclk;
    logic ws;
    logic sd;
  } i2s_lane_t;

  localparam int LANE_W = $bits(i2s_lane_t);

endpackage

// File: rtl/i2s_frame_counter.sv
module i2s_frame_counter #(
  parameter int CNT_W    = 8,
  parameter int BCLK_BIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk_q,
  output logic ws_q
);

  localparam int WS_BIT = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bclk_d, ws_d;

  // Next state: plain binary count, both taps read from the current count.
  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    bclk_d = cnt_q[BCLK_BIT];
    ws_d   = cnt_q[WS_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      ws_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
      ws_q   <= ws_d;
    end
  end

  // R4: frame strobe moves only together with a falling bit clock.
  p_ws_on_bclk_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_q != $past(ws_q)) |-> $fell(bclk_q));

  // R2: each bit-clock level lasts at least two master cycles.
  p_bclk_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_q != $past(bclk_q)) |=> $stable(bclk_q));

endmodule

// File: rtl/i2s_sync_pipe.sv
module i2s_sync_pipe #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [W-1:0] stg_d;
      if (i == 0) begin : g_first
        always_comb stg_d = din;
      end else begin : g_rest
        always_comb stg_d = stg_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_d;
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/i2s_bclk_delay.sv
module i2s_bclk_delay #(
  parameter int DLY_MAX = 3,
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_in,
  input  logic             ws_in,
  input  logic             sd_in,
  input  logic [SEL_W-1:0] dly_sel,
  output logic             bclk_out,
  output logic             ws_out,
  output logic             sd_out
);

  logic [DLY_MAX-1:0] sh_q, sh_d;
  logic [SEL_W-1:0]   dly_q, dly_d, sel_clamped;
  logic               ws_prev_q;
  logic               ws_edge;
  logic [DLY_MAX:0]   taps;
  logic               bclk_d;

  always_comb begin
    ws_edge     = ws_in ^ ws_prev_q;
    sel_clamped = (dly_sel > SEL_W'(DLY_MAX)) ? SEL_W'(DLY_MAX) : dly_sel;
    dly_d       = ws_edge ? sel_clamped : dly_q;
    sh_d[0]     = bclk_in;
    for (int i = 1; i < DLY_MAX; i++) sh_d[i] = sh_q[i-1];
    taps[0]     = bclk_in;
    for (int i = 0; i < DLY_MAX; i++) taps[i+1] = sh_q[i];
    bclk_d      = taps[dly_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      dly_q     <= '0;
      ws_prev_q <= 1'b0;
      bclk_out  <= 1'b0;
      ws_out    <= 1'b0;
      sd_out    <= 1'b0;
    end else begin
      sh_q      <= sh_d;
      dly_q     <= dly_d;
      ws_prev_q <= ws_in;
      bclk_out  <= bclk_d;
      ws_out    <= ws_in;
      sd_out    <= sd_in;
    end
  end

  // R8: the delay setting holds while the frame strobe is steady.
  p_dly_hold_mid_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_in == ws_prev_q) |=> $stable(dly_q));

  // R7: with no delay, the output follows the source one cycle later.
  p_bclk_lag0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q == '0 && $past(dly_q) == '0) |-> (bclk_out == $past(bclk_in)));

  // R7: with one cycle of delay, the output follows the source two cycles later.
  p_bclk_lag1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q == SEL_W'(1) && $past(dly_q) == SEL_W'(1)) |->
      (bclk_out == $past(bclk_in, 2)));

endmodule

// File: rtl/i2s_sync_reclock.sv
module i2s_sync_reclock
  import i2s_rc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int BCLK_BIT    = 1,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_MAX     = 3,
  localparam int SEL_W      = (DLY_MAX < 2) ? 1 : $clog2(DLY_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_mode,
  input  logic [SEL_W-1:0] dly_sel,
  input  logic             s_bclk,
  input  logic             s_ws,
  input  logic             sd_in,
  output logic             bclk_out,
  output logic             ws_out,
  output logic             sd_out
);

  // Reset: asserted at once, released on the master clock.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic gen_bclk, gen_ws;

  i2s_frame_counter #(
    .CNT_W    (CNT_W),
    .BCLK_BIT (BCLK_BIT)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .bclk_q (gen_bclk),
    .ws_q   (gen_ws)
  );

  i2s_lane_t lane_raw, lane_sync;
  logic [LANE_W-1:0] lane_sync_bits;

  always_comb begin
    lane_raw.bclk = s_bclk;
    lane_raw.ws   = s_ws;
    lane_raw.sd   = sd_in;
  end

  i2s_sync_pipe #(
    .STAGES (SYNC_STAGES),
    .W      (LANE_W)
  ) u_retime (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (lane_raw),
    .dout  (lane_sync_bits)
  );

  assign lane_sync = i2s_lane_t'(lane_sync_bits);

  logic bclk_src, ws_src;
  always_comb begin
    bclk_src = master_mode ? gen_bclk : lane_sync.bclk;
    ws_src   = master_mode ? gen_ws   : lane_sync.ws;
  end

  i2s_bclk_delay #(
    .DLY_MAX (DLY_MAX),
    .SEL_W   (SEL_W)
  ) u_delay (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bclk_in  (bclk_src),
    .ws_in    (ws_src),
    .sd_in    (lane_sync.sd),
    .dly_sel  (dly_sel),
    .bclk_out (bclk_out),
    .ws_out   (ws_out),
    .sd_out   (sd_out)
  );

  // R1: all outputs are low whenever the reset input is low.
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!bclk_out && !ws_out && !sd_out));

endmodule

// File: tb/i2s_sync_reclock_bench.sv
module i2s_sync_reclock_bench;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       master_mode;
  logic [1:0] dly_sel;
  logic       s_bclk, s_ws, sd_in;
  logic       bclk_out, ws_out, sd_out;

  int n_checks = 0;
  int n_fails  = 0;
  int e        = 0;
  int tcnt     = 0;
  bit done     = 1'b0;
  logic [2:0] hs [8];   // {bclk, ws, sd} captured per edge

  // Rows: bit 2 = master_mode, bits 1:0 = delay.
  localparam logic [2:0] ROWS [8] = '{3'b100, 3'b101, 3'b110, 3'b111,
                                      3'b000, 3'b010, 3'b011, 3'b001};

  always #(CLK_P/2) clk = ~clk;

  i2s_sync_reclock u_i2s_sync_reclock (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .dly_sel(dly_sel),
    .s_bclk(s_bclk), .s_ws(s_ws), .sd_in(sd_in),
    .bclk_out(bclk_out), .ws_out(ws_out), .sd_out(sd_out)
  );

  always @(posedge clk) begin
    if (!rst_n) e = 0;
    else begin
      e = e + 1;
      hs[e % 8] = {s_bclk, s_ws, sd_in};
    end
  end

  function automatic logic cbit(int idx, int b);
    if (idx < 0) return 1'b0;
    return logic'(((idx % 256) >> b) & 1);
  endfunction

  // Captured input bit k (2=bclk,1=ws,0=sd) at edge idx; 0 before retiming runs.
  function automatic logic hbit(int idx, int k);
    if (idx < 3) return 1'b0;
    return hs[idx % 8][k];
  endfunction

  task automatic drive_next();
    tcnt++;
    s_bclk = logic'((tcnt / 3) % 2);
    s_ws   = logic'((tcnt / 48) % 2);
    sd_in  = logic'($urandom % 2);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive_next();
    end
  endtask

  // Compare n cycles against the requirement formulas with delay d.
  task automatic check_run(int n, int d, string tag);
    int errs = 0;
    logic ab = 0, aw = 0, as_ = 0, xb = 0, xw = 0, xs = 0;
    for (int i = 0; i < n; i++) begin
      logic eb, ew, es;
      @(negedge clk);
      if (master_mode) begin
        eb = cbit(e - 4 - d, 1);
        ew = cbit(e - 4, 7);
      end else begin
        eb = hbit(e - 2 - d, 2);
        ew = hbit(e - 2, 1);
      end
      es = hbit(e - 2, 0);
      if (bclk_out !== eb || ws_out !== ew || sd_out !== es) begin
        if (errs == 0) begin
          ab = bclk_out; aw = ws_out; as_ = sd_out; xb = eb; xw = ew; xs = es;
        end
        errs++;
      end
      drive_next();
    end
    n_checks++;
    if (errs != 0) begin
      n_fails++;
      $display("FAIL %s: %0d cycles wrong, first actual b/w/s=%b%b%b expected %b%b%b",
               tag, errs, ab, aw, as_, xb, xw, xs);
    end
  endtask

  task automatic check_quiet(string tag);
    n_checks++;
    if (bclk_out !== 1'b0 || ws_out !== 1'b0 || sd_out !== 1'b0) begin
      n_fails++;
      $display("FAIL %s: actual b/w/s=%b%b%b expected 000", tag, bclk_out, ws_out, sd_out);
    end
  endtask

  task automatic wait_ws_toggle();
    logic prev = ws_out;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      drive_next();
      if (ws_out !== prev) break;
    end
  endtask

  initial begin
    rst_n = 1'b0; master_mode = 1'b0; dly_sel = 2'd0;
    s_bclk = 1'b1; s_ws = 1'b1; sd_in = 1'b1;
    repeat (5) @(negedge clk);
    check_quiet("R1 reset with active inputs");

    // Fresh start in master mode, d = 0.
    master_mode = 1'b1;
    sd_in = 1'b0;
    rst_n = 1'b1;
    check_run(600, 0, "R2 R3 R4 R5 master start d0");

    // Table walk over modes and delays (R2, R3, R5, R6, R7).
    for (int r = 0; r < 8; r++) begin
      master_mode = ROWS[r][2];
      dly_sel     = ROWS[r][1:0];
      idle(300);
      check_run(256, int'(ROWS[r][1:0]),
                ROWS[r][2] ? "R2 R3 R7 master row" : "R6 R7 R5 slave row");
    end

    // R8: change within a frame is ignored until the next frame edge.
    master_mode = 1'b1;
    dly_sel = 2'd3;
    idle(300);
    wait_ws_toggle();
    dly_sel = 2'd0;
    check_run(100, 3, "R8 mid-frame change ignored");
    wait_ws_toggle();
    idle(4);
    check_run(100, 0, "R8 new delay after frame edge");

    // R9: asynchronous reset between edges.
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      drive_next();
      if (ws_out === 1'b1 && bclk_out === 1'b1) break;
    end
    #2;
    rst_n = 1'b0;
    #1;
    check_quiet("R9 async clear");
    repeat (3) @(negedge clk);
    check_quiet("R1 held in reset");

    // Restart: delay returns to 0 after reset (R8), frame restarts low (R3).
    dly_sel = 2'd2;
    rst_n = 1'b1;
    check_run(100, 0, "R8 R3 restart with d0");

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule